// File: doc/BRIEF.md
# Local-Initiated DMA Transfer Controller

This block sequences bus-master block transfers in two directions. The read channel moves data from host memory toward the local side. The write channel moves data from the local side out to host memory. Each channel has a start address register and a byte-count register. A configuration pin decides which side may program those registers. With the pin low, only the local side may write them. With the pin high, only the host side may write them.

A per-channel enable pin starts a channel. The channel then issues one beat request per 32-bit word on a valid/ready interface, which stands in for the real bus signalling. Each accepted beat advances the address and reduces the count. A channel stops when the count runs out, unless the count-ignore pin is high; in that case it streams for as long as it is enabled.

When a transfer finishes, the block sets a sticky completion bit. It raises the interrupt of the side that programmed that channel's count. Beat requests follow the usual back-pressure rules. A raised request holds its address and byte enables until ready is seen high at a clock edge. Dropping enable or a FIFO condition never withdraws a request that is already raised; it only prevents the next one.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset both beat-valid outputs are low, the status vector is zero and both interrupt outputs are low.
- R2: Register selects are 0 read address, 1 read count, 2 write address, 3 write count and 4 status. With `cfg_host_prog` low, local-port writes to selects 0 to 3 load the register, and host-port writes to them have no effect.
- R3: With `cfg_host_prog` high, host-port writes to selects 0 to 3 load the register, and local-port writes to them have no effect.
- R4: A channel raises beat-valid one cycle after it sees enable high, a nonzero count (or count-ignore high) and no FIFO block. Once raised, valid, address and byte enables stay unchanged until ready is high at a clock edge.
- R5: Each accepted beat adds 4 to the address and subtracts 4 from the count. A beat whose remaining count is 4 or more carries byte enables 4'b1111, and a following beat is offered in the next cycle without a gap.
- R6: When fewer than 4 bytes remain, the beat enables only the low bytes: 1 byte gives 4'b0001, 2 bytes give 4'b0011 and 3 bytes give 4'b0111. No beat follows the one that brings the count to zero.
- R7: With `count_ignore` high, beats continue regardless of the count, including a count of zero. The count is not changed and no completion is signalled.
- R8: A read beat is not raised while `h2l_fifo_full` is high, and a write beat is not raised while `l2h_fifo_empty` is high.
- R9: Dropping enable lets the raised beat complete and then issues no further beat. Raising enable again resumes at the kept address and count.
- R10: On completion, the block sets a status bit chosen by the side that last loaded the channel's count: bit 0 for a local read, bit 1 for a local write, bit 2 for a host read, bit 3 for a host write. `loc_irq` is high while bit 0 or 1 is set, and `hst_irq` is high while bit 2 or 3 is set.
- R11: Status bits stay set until cleared by a write of one to select 4. The local port clears only bits 1:0 and the host port clears only bits 3:2, whatever the value of `cfg_host_prog`. A completion in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_host_prog | input | 1 | 0: local side programs channels; 1: host side programs them |
| count_ignore | input | 1 | Stream without regard to the count |
| loc_wr_en | input | 1 | Local-port register write strobe |
| loc_wr_sel | input | 3 | Local-port register select |
| loc_wr_data | input | 32 | Local-port write data |
| hst_wr_en | input | 1 | Host-port register write strobe |
| hst_wr_sel | input | 3 | Host-port register select |
| hst_wr_data | input | 32 | Host-port write data |
| rd_enable | input | 1 | Read channel enable |
| wr_enable | input | 1 | Write channel enable |
| h2l_fifo_full | input | 1 | Host-to-local FIFO full; blocks read beats |
| l2h_fifo_empty | input | 1 | Local-to-host FIFO empty; blocks write beats |
| rd_beat_valid | output | 1 | Read beat request |
| rd_beat_ready | input | 1 | Read beat accepted |
| rd_beat_addr | output | 32 | Read beat address |
| rd_beat_be | output | 4 | Read beat byte enables |
| wr_beat_valid | output | 1 | Write beat request |
| wr_beat_ready | input | 1 | Write beat accepted |
| wr_beat_addr | output | 32 | Write beat address |
| wr_beat_be | output | 4 | Write beat byte enables |
| irq_status | output | 4 | Sticky completion bits |
| loc_irq | output | 1 | Interrupt to the local side |
| hst_irq | output | 1 | Interrupt to the host side |

## Verification
A register write applies at the clock edge on which it is presented. A beat request then appears one edge after enable is seen with work pending. An accepted beat shows its new address on the same edge, and the completion bit and interrupt rise on the edge that accepts the final beat. A status clear also takes effect on its write edge. The bench drives every input on a falling edge and samples at the next falling edge, so each expected value is read exactly one rising edge after the stimulus that causes it. Stalls, pauses and FIFO blocks are held for several such samples to show that nothing moves.

// File: rtl/dmax_pkg.sv
package dmax_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_RD  = 0;
  localparam int CH_WR  = 1;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_RD_ADDR = 3'd0,
    SEL_RD_CNT  = 3'd1,
    SEL_WR_ADDR = 3'd2,
    SEL_WR_CNT  = 3'd3,
    SEL_STATUS  = 3'd4
  } reg_sel_e;

  typedef enum logic {
    SIDE_LOCAL = 1'b0,
    SIDE_HOST  = 1'b1
  } side_e;

  function automatic logic [SEL_W-1:0] addr_sel(input int ch);
    return (ch == CH_RD) ? SEL_RD_ADDR : SEL_WR_ADDR;
  endfunction

  function automatic logic [SEL_W-1:0] cnt_sel(input int ch);
    return (ch == CH_RD) ? SEL_RD_CNT : SEL_WR_CNT;
  endfunction

endpackage

// File: rtl/dmax_gate.sv
module dmax_gate
  import dmax_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              cfg_host_prog,
  input  logic              loc_we,
  input  logic [SEL_W-1:0]  loc_sel,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              hst_we,
  input  logic [SEL_W-1:0]  hst_sel,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [NUM_CH-1:0] addr_ld,
  output logic [NUM_CH-1:0] cnt_ld,
  output logic [DATA_W-1:0] ld_data,
  output side_e             ld_side,
  output logic [NUM_CH-1:0] clr_loc,
  output logic [NUM_CH-1:0] clr_hst
);

  logic             own_we;
  logic [SEL_W-1:0] own_sel;

  // Only the side named by the configuration pin reaches the channel registers.
  assign own_we  = cfg_host_prog ? hst_we    : loc_we;
  assign own_sel = cfg_host_prog ? hst_sel   : loc_sel;
  assign ld_data = cfg_host_prog ? hst_wdata : loc_wdata;
  assign ld_side = cfg_host_prog ? SIDE_HOST : SIDE_LOCAL;

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      addr_ld[ch] = own_we && (own_sel == addr_sel(ch));
      cnt_ld[ch]  = own_we && (own_sel == cnt_sel(ch));
    end
  end

  // Status clears are open to both sides, each on its own bits.
  assign clr_loc = (loc_we && loc_sel == SEL_STATUS) ? loc_wdata[NUM_CH-1:0] : '0;
  assign clr_hst = (hst_we && hst_sel == SEL_STATUS) ? hst_wdata[2*NUM_CH-1:NUM_CH] : '0;

endmodule

// File: rtl/dmax_chan.sv
module dmax_chan
  import dmax_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_ld,
  input  logic                  cnt_ld,
  input  logic [DATA_W-1:0]     ld_data,
  input  side_e                 ld_side,
  input  logic                  enable,
  input  logic                  blocked,
  input  logic                  ignore_cnt,
  input  logic                  req_ready,
  output logic                  req_valid,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [BEAT_BYTES-1:0] req_be,
  output logic                  done,
  output side_e                 done_side
);

  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_after;
  logic              pend_q;
  logic              pend_d;
  side_e             side_q;
  logic              fire;
  logic              whole;

  assign fire  = pend_q && req_ready;
  assign whole = ignore_cnt || (cnt_q >= CNT_STEP) || (cnt_q == '0);

  always_comb begin
    if (ignore_cnt)            cnt_after = cnt_q;
    else if (cnt_q >= CNT_STEP) cnt_after = cnt_q - CNT_STEP;
    else                        cnt_after = '0;
  end

  always_comb begin
    for (int i = 0; i < BEAT_BYTES; i++)
      req_be[i] = whole || (CNT_W'(i) < cnt_q);
  end

  // A raised request is held; a new one is raised only with work left.
  always_comb begin
    if (fire)
      pend_d = enable && !blocked && (ignore_cnt || cnt_after != '0);
    else if (!pend_q)
      pend_d = enable && !blocked && (ignore_cnt || cnt_q != '0);
    else
      pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      side_q <= SIDE_LOCAL;
    end else begin
      pend_q <= pend_d;
      if (addr_ld)   addr_q <= ld_data[ADDR_W-1:0];
      else if (fire) addr_q <= addr_q + ADDR_STEP;
      if (cnt_ld) begin
        cnt_q  <= ld_data[CNT_W-1:0];
        side_q <= ld_side;
      end else if (fire) begin
        cnt_q  <= cnt_after;
      end
    end
  end

  assign req_valid = pend_q;
  assign req_addr  = addr_q;
  assign done      = fire && !ignore_cnt && (cnt_after == '0);
  assign done_side = side_q;

endmodule

// File: rtl/dmax_irq.sv
module dmax_irq
  import dmax_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     done,
  input  side_e                 done_side [NUM_CH],
  input  logic [NUM_CH-1:0]     clr_loc,
  input  logic [NUM_CH-1:0]     clr_hst,
  output logic [2*NUM_CH-1:0]   status,
  output logic                  loc_irq,
  output logic                  hst_irq
);

  logic [NUM_CH-1:0] loc_q;
  logic [NUM_CH-1:0] hst_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        loc_q[ch] <= 1'b0;
        hst_q[ch] <= 1'b0;
      end else begin
        loc_q[ch] <= (loc_q[ch] && !clr_loc[ch]) || (done[ch] && done_side[ch] == SIDE_LOCAL);
        hst_q[ch] <= (hst_q[ch] && !clr_hst[ch]) || (done[ch] && done_side[ch] == SIDE_HOST);
      end
    end
  end

  assign status  = {hst_q, loc_q};
  assign loc_irq = |loc_q;
  assign hst_irq = |hst_q;

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dmax_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_host_prog,
  input  logic                  count_ignore,
  input  logic                  loc_wr_en,
  input  logic [SEL_W-1:0]      loc_wr_sel,
  input  logic [DATA_W-1:0]     loc_wr_data,
  input  logic                  hst_wr_en,
  input  logic [SEL_W-1:0]      hst_wr_sel,
  input  logic [DATA_W-1:0]     hst_wr_data,
  input  logic                  rd_enable,
  input  logic                  wr_enable,
  input  logic                  h2l_fifo_full,
  input  logic                  l2h_fifo_empty,
  output logic                  rd_beat_valid,
  input  logic                  rd_beat_ready,
  output logic [ADDR_W-1:0]     rd_beat_addr,
  output logic [BEAT_BYTES-1:0] rd_beat_be,
  output logic                  wr_beat_valid,
  input  logic                  wr_beat_ready,
  output logic [ADDR_W-1:0]     wr_beat_addr,
  output logic [BEAT_BYTES-1:0] wr_beat_be,
  output logic [2*NUM_CH-1:0]   irq_status,
  output logic                  loc_irq,
  output logic                  hst_irq
);

  logic [NUM_CH-1:0]     addr_ld, cnt_ld, clr_loc, clr_hst;
  logic [DATA_W-1:0]     ld_data;
  side_e                 ld_side;
  logic [NUM_CH-1:0]     ch_en, ch_blk, ch_ready, ch_valid, ch_done;
  logic [ADDR_W-1:0]     ch_addr [NUM_CH];
  logic [BEAT_BYTES-1:0] ch_be   [NUM_CH];
  side_e                 ch_side [NUM_CH];

  assign ch_en[CH_RD]    = rd_enable;
  assign ch_en[CH_WR]    = wr_enable;
  assign ch_blk[CH_RD]   = h2l_fifo_full;
  assign ch_blk[CH_WR]   = l2h_fifo_empty;
  assign ch_ready[CH_RD] = rd_beat_ready;
  assign ch_ready[CH_WR] = wr_beat_ready;

  dmax_gate #(.DATA_W(DATA_W)) u_gate (
    .cfg_host_prog (cfg_host_prog),
    .loc_we        (loc_wr_en),
    .loc_sel       (loc_wr_sel),
    .loc_wdata     (loc_wr_data),
    .hst_we        (hst_wr_en),
    .hst_sel       (hst_wr_sel),
    .hst_wdata     (hst_wr_data),
    .addr_ld       (addr_ld),
    .cnt_ld        (cnt_ld),
    .ld_data       (ld_data),
    .ld_side       (ld_side),
    .clr_loc       (clr_loc),
    .clr_hst       (clr_hst)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dmax_chan #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .DATA_W     (DATA_W),
      .BEAT_BYTES (BEAT_BYTES)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_ld    (addr_ld[ch]),
      .cnt_ld     (cnt_ld[ch]),
      .ld_data    (ld_data),
      .ld_side    (ld_side),
      .enable     (ch_en[ch]),
      .blocked    (ch_blk[ch]),
      .ignore_cnt (count_ignore),
      .req_ready  (ch_ready[ch]),
      .req_valid  (ch_valid[ch]),
      .req_addr   (ch_addr[ch]),
      .req_be     (ch_be[ch]),
      .done       (ch_done[ch]),
      .done_side  (ch_side[ch])
    );
  end

  dmax_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (ch_done),
    .done_side (ch_side),
    .clr_loc   (clr_loc),
    .clr_hst   (clr_hst),
    .status    (irq_status),
    .loc_irq   (loc_irq),
    .hst_irq   (hst_irq)
  );

  assign rd_beat_valid = ch_valid[CH_RD];
  assign rd_beat_addr  = ch_addr[CH_RD];
  assign rd_beat_be    = ch_be[CH_RD];
  assign wr_beat_valid = ch_valid[CH_WR];
  assign wr_beat_addr  = ch_addr[CH_WR];
  assign wr_beat_be    = ch_be[CH_WR];

endmodule

// File: rtl/dmax_chk.sv
module dmax_chk
  import dmax_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  loc_wr_en,
  input logic [SEL_W-1:0]      loc_wr_sel,
  input logic [DATA_W-1:0]     loc_wr_data,
  input logic                  hst_wr_en,
  input logic                  h2l_fifo_full,
  input logic                  l2h_fifo_empty,
  input logic                  rd_beat_valid,
  input logic                  rd_beat_ready,
  input logic [ADDR_W-1:0]     rd_beat_addr,
  input logic [BEAT_BYTES-1:0] rd_beat_be,
  input logic                  wr_beat_valid,
  input logic                  wr_beat_ready,
  input logic [ADDR_W-1:0]     wr_beat_addr,
  input logic [BEAT_BYTES-1:0] wr_beat_be,
  input logic [2*NUM_CH-1:0]   irq_status
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

  logic quiet;
  logic loc_clr0;
  assign quiet    = !loc_wr_en && !hst_wr_en;
  assign loc_clr0 = loc_wr_en && loc_wr_sel == SEL_STATUS && loc_wr_data[0];

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat_valid && !rd_beat_ready && quiet |=>
      rd_beat_valid && $stable(rd_beat_addr) && $stable(rd_beat_be));

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat_valid && !wr_beat_ready && quiet |=>
      wr_beat_valid && $stable(wr_beat_addr) && $stable(wr_beat_be));

  assert_rd_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_beat_valid) |-> !$past(h2l_fifo_full));

  assert_wr_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_beat_valid) |-> !$past(l2h_fifo_empty));

  assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat_valid && rd_beat_ready && quiet ##1 rd_beat_valid |->
      rd_beat_addr == $past(rd_beat_addr) + STEP);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[0] && !loc_clr0 |=> irq_status[0]);

endmodule

bind dma_xfer_ctrl dmax_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BEAT_BYTES (BEAT_BYTES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .loc_wr_en      (loc_wr_en),
  .loc_wr_sel     (loc_wr_sel),
  .loc_wr_data    (loc_wr_data),
  .hst_wr_en      (hst_wr_en),
  .h2l_fifo_full  (h2l_fifo_full),
  .l2h_fifo_empty (l2h_fifo_empty),
  .rd_beat_valid  (rd_beat_valid),
  .rd_beat_ready  (rd_beat_ready),
  .rd_beat_addr   (rd_beat_addr),
  .rd_beat_be     (rd_beat_be),
  .wr_beat_valid  (wr_beat_valid),
  .wr_beat_ready  (wr_beat_ready),
  .wr_beat_addr   (wr_beat_addr),
  .wr_beat_be     (wr_beat_be),
  .irq_status     (irq_status)
);

// File: tb/dma_xfer_ctrl_test.sv
module dma_xfer_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_host_prog = 1'b0, count_ignore = 1'b0;
  logic        loc_wr_en = 1'b0, hst_wr_en = 1'b0;
  logic [2:0]  loc_wr_sel = '0, hst_wr_sel = '0;
  logic [31:0] loc_wr_data = '0, hst_wr_data = '0;
  logic        rd_enable = 1'b0, wr_enable = 1'b0;
  logic        h2l_fifo_full = 1'b0, l2h_fifo_empty = 1'b0;
  logic        rd_beat_valid, wr_beat_valid;
  logic        rd_beat_ready = 1'b0, wr_beat_ready = 1'b0;
  logic [31:0] rd_beat_addr, wr_beat_addr;
  logic [3:0]  rd_beat_be, wr_beat_be;
  logic [3:0]  irq_status;
  logic        loc_irq, hst_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_xfer_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_host_prog(cfg_host_prog), .count_ignore(count_ignore),
    .loc_wr_en(loc_wr_en), .loc_wr_sel(loc_wr_sel), .loc_wr_data(loc_wr_data),
    .hst_wr_en(hst_wr_en), .hst_wr_sel(hst_wr_sel), .hst_wr_data(hst_wr_data),
    .rd_enable(rd_enable), .wr_enable(wr_enable),
    .h2l_fifo_full(h2l_fifo_full), .l2h_fifo_empty(l2h_fifo_empty),
    .rd_beat_valid(rd_beat_valid), .rd_beat_ready(rd_beat_ready),
    .rd_beat_addr(rd_beat_addr), .rd_beat_be(rd_beat_be),
    .wr_beat_valid(wr_beat_valid), .wr_beat_ready(wr_beat_ready),
    .wr_beat_addr(wr_beat_addr), .wr_beat_be(wr_beat_be),
    .irq_status(irq_status), .loc_irq(loc_irq), .hst_irq(hst_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic lw(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    loc_wr_en = 1'b1; loc_wr_sel = sel; loc_wr_data = data;
    @(negedge clk);
    loc_wr_en = 1'b0;
  endtask

  task automatic hw(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_wr_sel = sel; hst_wr_data = data;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd valid", 32'(rd_beat_valid), 0);
    chk("R1 wr valid", 32'(wr_beat_valid), 0);
    chk("R1 status", 32'(irq_status), 0);
    chk("R1 irqs", 32'({loc_irq, hst_irq}), 0);
  endtask

  task automatic t_local_prog();
    cfg_host_prog = 1'b0;
    lw(0, 32'h1000); lw(1, 8);
    hw(0, 32'h9000); hw(1, 100);
    rd_enable = 1'b1; rd_beat_ready = 1'b0;
    step();
    chk("R2 addr from local", rd_beat_addr, 32'h1000);
    chk("R4 valid raised", 32'(rd_beat_valid), 1);
    chk("R5 full be", 32'(rd_beat_be), 32'hF);
    step(2);
    chk("R4 held valid", 32'(rd_beat_valid), 1);
    chk("R4 held addr", rd_beat_addr, 32'h1000);
    rd_beat_ready = 1'b1;
    step();
    chk("R5 next addr", rd_beat_addr, 32'h1004);
    chk("R5 back-to-back", 32'(rd_beat_valid), 1);
    step();
    chk("R2 host count ignored, done after 8 bytes", 32'(rd_beat_valid), 0);
    chk("R10 local read bit", 32'(irq_status), 32'h1);
    chk("R10 irq steering", 32'({loc_irq, hst_irq}), 32'b10);
    rd_beat_ready = 1'b0; rd_enable = 1'b0;
    step();
    chk("R6 no beat after zero", 32'(rd_beat_valid), 0);
    lw(4, 32'h1);
    chk("R11 local clear", 32'(irq_status), 0);
  endtask

  task automatic t_host_prog();
    cfg_host_prog = 1'b1;
    hw(2, 32'h2000); hw(3, 6);
    lw(2, 32'h7770); lw(3, 40);
    wr_beat_ready = 1'b1; wr_enable = 1'b1;
    step();
    chk("R3 addr from host", wr_beat_addr, 32'h2000);
    chk("R3 first be", 32'(wr_beat_be), 32'hF);
    step();
    chk("R5 wr addr step", wr_beat_addr, 32'h2004);
    chk("R6 two-byte be", 32'(wr_beat_be), 32'h3);
    step();
    chk("R3 local count ignored", 32'(wr_beat_valid), 0);
    chk("R10 host write bit", 32'(irq_status), 32'h8);
    chk("R10 host irq", 32'({loc_irq, hst_irq}), 32'b01);
    wr_enable = 1'b0; wr_beat_ready = 1'b0;
    lw(4, 32'h8);
    chk("R11 local cannot clear host bit", 32'(irq_status), 32'h8);
    hw(4, 32'h8);
    chk("R11 host clear", 32'(irq_status), 0);
    cfg_host_prog = 1'b0;
  endtask

  task automatic t_ignore();
    count_ignore = 1'b1;
    lw(0, 32'h3000); lw(1, 0);
    rd_beat_ready = 1'b1; rd_enable = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R7 stream addr", rd_beat_addr, 32'h3000 + 32'(4 * k));
      chk("R7 stream valid", 32'(rd_beat_valid), 1);
    end
    rd_enable = 1'b0;
    step();
    chk("R9 stop after enable drop", 32'(rd_beat_valid), 0);
    chk("R7 no completion", 32'(irq_status), 0);
    count_ignore = 1'b0; rd_beat_ready = 1'b0;
  endtask

  task automatic t_fifo_block();
    h2l_fifo_full = 1'b1;
    lw(0, 32'h4000); lw(1, 4);
    rd_enable = 1'b1;
    step(3);
    chk("R8 read blocked by full", 32'(rd_beat_valid), 0);
    h2l_fifo_full = 1'b0;
    step();
    chk("R8 read after full clears", rd_beat_addr, 32'h4000);
    chk("R8 read valid", 32'(rd_beat_valid), 1);
    rd_beat_ready = 1'b1;
    step();
    chk("R10 read done", 32'(irq_status), 32'h1);
    rd_beat_ready = 1'b0; rd_enable = 1'b0;
    lw(4, 32'h1);
    l2h_fifo_empty = 1'b1;
    lw(2, 32'h5000); lw(3, 3);
    wr_enable = 1'b1;
    step(3);
    chk("R8 write blocked by empty", 32'(wr_beat_valid), 0);
    l2h_fifo_empty = 1'b0;
    step();
    chk("R8 write valid", 32'(wr_beat_valid), 1);
    chk("R6 three-byte be", 32'(wr_beat_be), 32'h7);
    wr_beat_ready = 1'b1;
    step();
    chk("R10 local write bit", 32'(irq_status), 32'h2);
    chk("R10 local irq", 32'(loc_irq), 1);
    wr_beat_ready = 1'b0; wr_enable = 1'b0;
    lw(4, 32'h2);
    chk("R11 clear write bit", 32'(irq_status), 0);
  endtask

  task automatic t_pause();
    lw(0, 32'h6000); lw(1, 12);
    rd_enable = 1'b1; rd_beat_ready = 1'b0;
    step();
    chk("R9 first beat", rd_beat_addr, 32'h6000);
    rd_enable = 1'b0; rd_beat_ready = 1'b1;
    step();
    chk("R9 paused", 32'(rd_beat_valid), 0);
    step(2);
    chk("R9 still paused", 32'(rd_beat_valid), 0);
    chk("R9 no done while paused", 32'(irq_status), 0);
    rd_enable = 1'b1;
    step();
    chk("R9 resume addr", rd_beat_addr, 32'h6004);
    step();
    chk("R9 resume next", rd_beat_addr, 32'h6008);
    step();
    chk("R9 count kept, done", 32'(irq_status), 32'h1);
    chk("R6 stops at zero", 32'(rd_beat_valid), 0);
    rd_enable = 1'b0; rd_beat_ready = 1'b0;
    lw(4, 32'h1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_local_prog();
    t_host_prog();
    t_ignore();
    t_fifo_block();
    t_pause();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

endmodule